// File: doc/BRIEF.md
# Parallel Port Enhanced Cycle Handshake Controller

This block turns single host I/O reads and writes at port offsets 3 through 7 into enhanced parallel port (EPP) strobe cycles. Offset 3 runs an address-strobe cycle. Offsets 4 to 7 run a data-strobe cycle. As soon as such an access appears, the host is held on a ready line. The peripheral paces the transfer through its busy line, and the host is released only after the peripheral has completed the busy handshake.

Busy passes through a synchronizer and then feeds two counters that run all the time. One measures how long busy has been low and the other how long it has been high. A strobe may begin only once busy has stayed low for at least `MIN_CLKS` cycles, and that time may already have passed before the host access arrives. A strobe ends only once busy has stayed high for at least `MIN_CLKS` cycles. For a write, the bus carries the host data while the strobe is low. For a read, peripheral data is captured at the edge where the strobe ends. After a cycle completes, the block waits for the host to release its read and write strobes before it accepts another access.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: A host read or write at an offset of 3 to 7 while the block is idle drives `ready_o` low in the same cycle, without waiting for a clock edge. Offsets 0 to 2 leave `ready_o` high and both strobes high, whatever busy does. `ready_o` is never low unless a host strobe is active.
- R2: Offset 3 uses `addr_stb_no` as the active strobe. Offsets 4 to 7 use `data_stb_no`. The two strobes are never low together.
- R3: In a write cycle, while the strobe is low, `write_no` is low, `pd_oe_o` is high and `pd_o` equals the host write data. In a read cycle, `write_no` stays high and `pd_oe_o` stays low.
- R4: While a request is pending, the active strobe falls exactly SYNC_STAGES+MIN_CLKS+1 clock edges after busy goes low. A busy low pulse shorter than MIN_CLKS cycles starts no strobe.
- R5: If busy has already been low for long enough, the active strobe falls on the second clock edge after the request appears.
- R6: The active strobe and `ready_o` rise on the same edge, exactly SYNC_STAGES+MIN_CLKS+1 edges after busy goes high. A busy high pulse shorter than MIN_CLKS cycles does not end the strobe.
- R7: In a read cycle, `pd_i` is captured at the edge where the strobe rises. The captured value appears on `host_rdata_o` and holds when `pd_i` changes later.
- R8: After a cycle completes, no new strobe starts while the host keeps its strobe asserted, even if busy goes low for a long time. `ready_o` stays high during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | ADDR_W | Host port offset |
| host_rd_i | input | 1 | Host read strobe, active high |
| host_wr_i | input | 1 | Host write strobe, active high; wins over read |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Peripheral data captured in the last read cycle |
| ready_o | output | 1 | Host ready; low stalls the host access |
| write_no | output | 1 | Write line to the peripheral, low during write cycles |
| addr_stb_no | output | 1 | Address strobe, active low |
| data_stb_no | output | 1 | Data strobe, active low |
| busy_i | input | 1 | Peripheral busy, asynchronous |
| pd_i | input | DATA_W | Peripheral data bus input |
| pd_o | output | DATA_W | Peripheral data bus output |
| pd_oe_o | output | 1 | Drive enable for the peripheral data bus |

## Verification
On every cycle, the assertions check the following. The two strobes are never low together. A strobe falls only after a filtered busy-low qualification. A strobe rises only together with ready and after a busy-high qualification. Ready is never low without a host strobe, and the bus is driven only during a write strobe. Only the bench scenarios can show the exact edge counts from a busy transition to a strobe edge, the rejection of short busy pulses in both directions, the offset-to-strobe mapping across all eight offsets for reads and writes, the value and hold of captured read data, and the refusal to start a second cycle until the host releases its strobe.

// File: rtl/epp_cyc_pkg.sv
package epp_cyc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_LO = 2'd1,
    ST_STROBE  = 2'd2,
    ST_DONE    = 2'd3
  } epp_state_e;

  // offset using the address strobe; higher offsets use the data strobe
  localparam int unsigned EPP_ADDR_OFS = 3;
endpackage

// File: rtl/epp_level_timer.sv
module epp_level_timer #(
  parameter int unsigned MIN_CLKS = 8,
  parameter bit          LEVEL    = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic ok_o
);
  localparam int unsigned CNT_W = (MIN_CLKS < 1) ? 1 : $clog2(MIN_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CLKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sig_i == LEVEL) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign ok_o = (cnt_q >= CNT_MAX);
endmodule

// File: rtl/epp_busy_filter.sv
module epp_busy_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_CLKS    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic low_ok_o,
  output logic high_ok_o
);
  logic busy_s;
  logic [1:0] ok;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign busy_s = busy_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], busy_i} ;
      end
      assign busy_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  // index 0 times busy low, index 1 times busy high
  for (genvar lv = 0; lv < 2; lv++) begin : g_timer
    epp_level_timer #(
      .MIN_CLKS(MIN_CLKS),
      .LEVEL   (lv[0])
    ) u_timer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (busy_s),
      .ok_o  (ok[lv])
    );
  end

  assign low_ok_o  = ok[0];
  assign high_ok_o = ok[1];
endmodule

// File: rtl/epp_cyc_seq.sv
module epp_cyc_seq
  import epp_cyc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic              low_ok_i,
  input  logic              high_ok_i,
  output logic              ready_o,
  output logic              write_no,
  output logic              addr_stb_no,
  output logic              data_stb_no,
  output logic              pd_oe_o,
  output logic              load_wr_o,
  output logic              latch_rd_o
);
  localparam logic [ADDR_W-1:0] ADDR_OFS = ADDR_W'(EPP_ADDR_OFS);

  epp_state_e state_q, state_d;
  logic       is_addr_q, is_wr_q;
  logic       host_act, hit, strobe_on, in_cycle;

  assign host_act = host_rd_i | host_wr_i;
  assign hit      = host_act && (host_addr_i >= ADDR_OFS);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (hit)       state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (low_ok_i)  state_d = ST_STROBE;
      ST_STROBE:  if (high_ok_i) state_d = ST_DONE;
      ST_DONE:    if (!host_act) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      is_addr_q <= 1'b0;
      is_wr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && hit) begin
        is_addr_q <= (host_addr_i == ADDR_OFS);
        is_wr_q   <= host_wr_i;
      end
    end
  end

  assign strobe_on = (state_q == ST_STROBE);
  assign in_cycle  = (state_q == ST_WAIT_LO) || strobe_on;

  // ready drops combinationally on a decoded hit
  assign ready_o     = !((state_q == ST_IDLE && hit) || in_cycle);
  assign write_no    = !(is_wr_q && in_cycle);
  assign addr_stb_no = !(strobe_on && is_addr_q);
  assign data_stb_no = !(strobe_on && !is_addr_q);
  assign pd_oe_o     = strobe_on && is_wr_q;
  assign load_wr_o   = (state_q == ST_WAIT_LO) && low_ok_i && is_wr_q;
  assign latch_rd_o  = strobe_on && high_ok_i && !is_wr_q;
endmodule

// File: rtl/epp_cyc_data.sv
module epp_cyc_data #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_wr_i,
  input  logic              latch_rd_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic [DATA_W-1:0] pd_i,
  output logic [DATA_W-1:0] pd_o,
  output logic [DATA_W-1:0] host_rdata_o
);
  logic [DATA_W-1:0] out_q, in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      if (load_wr_i)  out_q <= host_wdata_i;
      if (latch_rd_i) in_q  <= pd_i;
    end
  end

  assign pd_o         = out_q;
  assign host_rdata_o = in_q;
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl #(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MIN_CLKS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              ready_o,
  output logic              write_no,
  output logic              addr_stb_no,
  output logic              data_stb_no,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] pd_i,
  output logic [DATA_W-1:0] pd_o,
  output logic              pd_oe_o
);
  logic low_ok, high_ok, load_wr, latch_rd;

  epp_busy_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_CLKS   (MIN_CLKS)
  ) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_i),
    .low_ok_o (low_ok),
    .high_ok_o(high_ok)
  );

  epp_cyc_seq #(
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_addr_i(host_addr_i),
    .host_rd_i  (host_rd_i),
    .host_wr_i  (host_wr_i),
    .low_ok_i   (low_ok),
    .high_ok_i  (high_ok),
    .ready_o    (ready_o),
    .write_no   (write_no),
    .addr_stb_no(addr_stb_no),
    .data_stb_no(data_stb_no),
    .pd_oe_o    (pd_oe_o),
    .load_wr_o  (load_wr),
    .latch_rd_o (latch_rd)
  );

  epp_cyc_data #(
    .DATA_W(DATA_W)
  ) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_wr_i   (load_wr),
    .latch_rd_i  (latch_rd),
    .host_wdata_i(host_wdata_i),
    .pd_i        (pd_i),
    .pd_o        (pd_o),
    .host_rdata_o(host_rdata_o)
  );
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic host_rd_i,
  input logic host_wr_i,
  input logic ready_o,
  input logic write_no,
  input logic addr_stb_no,
  input logic data_stb_no,
  input logic pd_oe_o,
  input logic low_ok_i,
  input logic high_ok_i
);
  assert_one_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!addr_stb_no, !data_stb_no}));

  assert_stall_in_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_stb_no || !data_stb_no) |-> !ready_o);

  assert_stall_needs_host_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (host_rd_i || host_wr_i));

  assert_astb_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_stb_no) |-> $past(low_ok_i));

  assert_dstb_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_stb_no) |-> $past(low_ok_i));

  assert_astb_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_stb_no) |-> (ready_o && $past(high_ok_i)));

  assert_dstb_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_stb_no) |-> (ready_o && $past(high_ok_i)));

  assert_drive_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_oe_o |-> (!write_no && (!addr_stb_no || !data_stb_no)));
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_rd_i  (host_rd_i),
  .host_wr_i  (host_wr_i),
  .ready_o    (ready_o),
  .write_no   (write_no),
  .addr_stb_no(addr_stb_no),
  .data_stb_no(data_stb_no),
  .pd_oe_o    (pd_oe_o),
  .low_ok_i   (low_ok),
  .high_ok_i  (high_ok)
);

// File: tb/test_epp_cycle_ctrl.sv
module test_epp_cycle_ctrl;
  localparam int MIN  = 8;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + MIN + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0, busy = 1'b1;
  logic [7:0] wdata = '0, pdin = '0;
  logic [7:0] rdata, pdout;
  logic       ready, write_n, astb_n, dstb_n, pd_oe;

  int tests = 0, failed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  epp_cycle_ctrl #(.ADDR_W(3), .DATA_W(8), .MIN_CLKS(MIN), .SYNC_STAGES(SYNC)) i_epp_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_rd_i(rd), .host_wr_i(wr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .ready_o(ready), .write_no(write_n),
    .addr_stb_no(astb_n), .data_stb_no(dstb_n), .busy_i(busy), .pd_i(pdin),
    .pd_o(pdout), .pd_oe_o(pd_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // waits for the active strobe (want_low=1) or ready (want_low=0) and returns edges taken
  task automatic wait_edges(input bit want_low, output int got);
    got = 99;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (want_low && (!astb_n || !dstb_n)) begin got = k; break; end
      if (!want_low && ready) begin got = k; break; end
    end
  endtask

  task automatic run_cycle(input int a, input bit w, input bit glitch);
    int got;
    logic [7:0] d, p;
    d = 8'((a * 37 + (w ? 91 : 0) + 5) & 255);
    p = 8'((a * 53) ^ 8'hA5);
    addr = 3'(a); wdata = d; wr = w; rd = !w;
    #1;
    if (a < 3) begin
      chk(ready, "R1 offset<3 ready", int'(ready), 1);
      busy = 1'b0;
      for (int i = 0; i < LAT + 3; i++) begin
        tick(1);
        if (!ready || !astb_n || !dstb_n) begin
          chk(0, "R1 offset<3 inactive", int'({ready, astb_n, dstb_n}), 7);
          break;
        end
      end
      chk(ready && astb_n && dstb_n, "R1 offset<3 inactive", int'({ready, astb_n, dstb_n}), 7);
      busy = 1'b1;
      tick(LAT + 3);
      rd = 0; wr = 0;
      tick(1);
      return;
    end
    chk(!ready, "R1 ready immediate", int'(ready), 0);
    tick(3);
    chk(!ready && astb_n && dstb_n, "R1 stalled before busy low", int'({ready, astb_n, dstb_n}), 3);
    if (glitch) begin
      busy = 1'b0; tick(MIN - 1); busy = 1'b1;
      tick(15);
      chk(astb_n && dstb_n, "R4 short low pulse ignored", int'({astb_n, dstb_n}), 3);
    end
    busy = 1'b0;
    wait_edges(1'b1, got);
    chk(got == LAT, "R4 strobe fall latency", got, LAT);
    chk(astb_n == (a != 3), "R2 address strobe select", int'(astb_n), int'(a != 3));
    chk(dstb_n == (a == 3), "R2 data strobe select", int'(dstb_n), int'(a == 3));
    chk(write_n == !w, "R3 write line", int'(write_n), int'(!w));
    chk(pd_oe == w, "R3 bus enable", int'(pd_oe), int'(w));
    if (w) chk(pdout == d, "R3 bus data", int'(pdout), int'(d));
    pdin = p;
    if (glitch) begin
      tick(5);
      busy = 1'b1; tick(MIN - 1); busy = 1'b0;
      tick(15);
      chk(!astb_n || !dstb_n, "R6 short high pulse ignored", int'({astb_n, dstb_n}), 1);
    end
    busy = 1'b1;
    wait_edges(1'b0, got);
    chk(got == LAT, "R6 ready rise latency", got, LAT);
    chk(astb_n && dstb_n, "R6 strobe rises with ready", int'({astb_n, dstb_n}), 3);
    pdin = ~p;
    busy = 1'b0;
    for (int i = 0; i < LAT + 3; i++) begin
      tick(1);
      if (!astb_n || !dstb_n || !ready) begin
        chk(0, "R8 no restart while host held", int'({ready, astb_n, dstb_n}), 7);
        break;
      end
    end
    chk(ready && astb_n && dstb_n, "R8 no restart while host held", int'({ready, astb_n, dstb_n}), 7);
    if (!w) chk(rdata == p, "R7 read data held", int'(rdata), int'(p));
    busy = 1'b1;
    rd = 0; wr = 0;
    tick(LAT + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    int got;
    tick(3);
    rst_n = 1'b1;
    tick(LAT + 2);
    chk(ready && astb_n && dstb_n && write_n && !pd_oe, "R1 reset state",
        int'({ready, astb_n, dstb_n, write_n, pd_oe}), 5'b11110);
    for (int a = 0; a < 8; a++)
      for (int w = 0; w < 2; w++)
        run_cycle(a, w[0], (a == 5) || (a == 3 && w == 1));

    // busy already qualified before the request
    busy = 1'b0;
    tick(LAT + 5);
    addr = 3'd6; rd = 1'b1;
    wait_edges(1'b1, got);
    chk(got == 2, "R5 pre-qualified busy latency", got, 2);
    chk(!dstb_n && astb_n, "R5 data strobe", int'({astb_n, dstb_n}), 2);
    pdin = 8'h3C;
    busy = 1'b1;
    wait_edges(1'b0, got);
    chk(got == LAT, "R6 ready rise latency", got, LAT);
    pdin = 8'hC3;
    tick(2);
    chk(rdata == 8'h3C, "R7 captured on trailing edge", int'(rdata), 8'h3C);
    rd = 1'b0;
    tick(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule